// File: doc/BRIEF.md
# Training Sequence Burst Detector

This block scans a stream of hard-decision bits for a burst's training sequences. A `start` pulse begins a scan. It captures a three-bit search-enable mask and a skip count, and the stream then arrives one bit per accepted cycle. The final bit carries an end marker. Three sequences are searched, each enabled by its own mask bit:

- a 38-bit synchronization pattern;
- two 22-bit normal patterns.

The block reports the earliest start position at which an enabled sequence lies completely inside the input, or reports that there is none.

After a hit, the first twelve bits of the scanned input are compared with the direct-mode preamble that belongs to the matched sequence. When they agree, the burst is reported as the direct-mode variant; otherwise it is reported as the trunked variant. One single-cycle strobe carries the type code and the start position. The block is meant to sit between a bit slicer and a burst demultiplexer that cuts the burst into its logical blocks.

Top module: `burst_seq_finder`

## Requirements
- R1: After reset `det_valid` is low and `det_type` is 0. No strobe appears until a scan has been started.
- R2: The sync sequence is, first bit to last, 11000001100111001110100111000001100111. Finding it reports trunked type 1 with `det_offset` equal to its start position. Position 0 is the first bit accepted after `start`.
- R3: Normal-1 (1101000011101001110100) reports type 2. Normal-2 (0111101001000011011110) reports type 3. In both cases the offset is the start position.
- R4: Mask bit 0 enables sync, bit 1 enables normal-1 and bit 2 enables normal-2. An occurrence of a disabled sequence is never reported.
- R5: The smallest start position holding any enabled sequence wins. At one position the order of precedence is sync, then normal-1, then normal-2.
- R6: Start positions below `skip` are not considered. A start position equal to `skip` is.
- R7: A sequence matches only if all of its bits lie within the input, up to and including the bit marked `bit_last`.
- R8: If no enabled sequence matches, a strobe reports type 0 and offset 0.
- R9: The direct-mode preambles, first bit to last, are P1 = 001100100011, P2 = 100110101001 and P3 = 000101000111. If input bits 0 to 11 equal the preamble paired with the hit, the type becomes direct mode:
  - sync with P3 gives 5;
  - normal-1 with P1 gives 6;
  - normal-2 with P2 gives 7.

  A different preamble leaves the trunked type.
- R10: `det_valid` is high for exactly one cycle per scan, and `det_type` is never 4.
- R11: Latency is fixed:
  - A hit at start position p is strobed one rising edge after the edge that accepts bit p+37.
  - If the input ends (n bits) before bit p+37, the hit is strobed p+38-n+1 edges after the edge that accepts the last bit.
  - A no-match result is strobed 17 edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new scan and captures `mask` and `skip` |
| mask | input | 3 | Search enables: bit 0 sync, bit 1 normal-1, bit 2 normal-2 |
| skip | input | W | First start position considered |
| bit_valid | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Stream bit |
| bit_last | input | 1 | Marks the final bit of the stream |
| det_valid | output | 1 | One-cycle result strobe |
| det_type | output | 3 | 0 none, 1 sync, 2 normal-1, 3 normal-2, 5/6/7 their direct-mode variants |
| det_offset | output | W | Start position of the reported sequence, 0 when none |

## Verification
A window starting at position p is judged one cycle after bit p+37 is accepted, so a hit is strobed one edge later. Windows that run past the end of the input are judged during up to 16 padding cycles after the last bit. A no-match result follows 17 edges after the last bit.

The bench records the cycle at which every bit is accepted. It watches for the strobe from a parallel thread, then compares the cycle of the strobe with the cycle predicted from the deciding bit. This keeps the timing check independent of the random gaps in `bit_valid`. Type and offset are taken at that strobe, and the cycle after it is checked to be low.

// File: rtl/burst_seq_finder.sv
module burst_seq_finder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   mask,
  input  logic [W-1:0] skip,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic         bit_last,
  output logic         det_valid,
  output logic [2:0]   det_type,
  output logic [W-1:0] det_offset
);
  localparam int YL   = 38;
  localparam int NL   = 22;
  localparam int PL   = 12;
  localparam int TAIL = YL - NL;
  localparam int PW   = $clog2(TAIL + 1);
  localparam logic [YL-1:0] SYNC_SEQ = 38'b11000001100111001110100111000001100111;
  localparam logic [NL-1:0] NRM1_SEQ = 22'b1101000011101001110100;
  localparam logic [NL-1:0] NRM2_SEQ = 22'b0111101001000011011110;
  localparam logic [PL-1:0] PRE_N1   = 12'b001100100011;
  localparam logic [PL-1:0] PRE_N2   = 12'b100110101001;
  localparam logic [PL-1:0] PRE_SY   = 12'b000101000111;

  typedef enum logic [1:0] {IDLE, SCAN, FLUSH} phase_t;

  phase_t        ph;
  logic [YL-1:0] hist;
  logic [W-1:0]  cnt;
  logic [PW-1:0] pads;
  logic [PL-1:0] pre;
  logic [2:0]    msk;
  logic [W-1:0]  skp;

  logic [W-1:0] pos;
  logic in_rng, hit_y, hit_n1, hit_n2, any, give_up, take, shift_en, dmo;
  logic [2:0] ftype;

  assign pos    = cnt - W'(YL);
  assign in_rng = (cnt >= W'(YL)) && (pos >= skp) && (ph != IDLE);
  assign hit_y  = msk[0] && (pads == '0) && in_rng && (hist == SYNC_SEQ);
  assign hit_n1 = msk[1] && (pads <= PW'(TAIL)) && in_rng && (hist[YL-1 -: NL] == NRM1_SEQ);
  assign hit_n2 = msk[2] && (pads <= PW'(TAIL)) && in_rng && (hist[YL-1 -: NL] == NRM2_SEQ);
  assign any    = hit_y | hit_n1 | hit_n2;

  assign dmo   = hit_y ? (pre == PRE_SY) : hit_n1 ? (pre == PRE_N1) : (pre == PRE_N2);
  assign ftype = {dmo, hit_y ? 2'd1 : hit_n1 ? 2'd2 : 2'd3};

  assign give_up  = (ph == FLUSH) && (pads == PW'(TAIL)) && !any;
  assign take     = (ph == SCAN) && bit_valid && !any;
  assign shift_en = take || ((ph == FLUSH) && !any && !give_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= IDLE;
      hist       <= '0;
      cnt        <= '0;
      pads       <= '0;
      pre        <= '0;
      msk        <= '0;
      skp        <= '0;
      det_valid  <= 1'b0;
      det_type   <= '0;
      det_offset <= '0;
    end else begin
      det_valid <= 1'b0;
      if (start) begin
        ph   <= SCAN;
        hist <= '0;
        cnt  <= '0;
        pads <= '0;
        pre  <= '0;
        msk  <= mask;
        skp  <= skip;
      end else begin
        if (any || give_up) begin
          ph         <= IDLE;
          det_valid  <= 1'b1;
          det_type   <= any ? ftype : 3'd0;
          det_offset <= any ? pos : '0;
        end else if (take && bit_last) begin
          ph <= FLUSH;
        end
        if (shift_en) begin
          hist <= {hist[YL-2:0], (ph == SCAN) ? bit_in : 1'b0};
          cnt  <= cnt + 1'b1;
          if (ph == FLUSH) pads <= pads + 1'b1;
          if (ph == SCAN && cnt < W'(PL)) pre <= {pre[PL-2:0], bit_in};
        end
      end
    end
  end

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |=> !det_valid);
  a_r10_legal_type: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> det_type != 3'd4);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == IDLE) |=> !det_valid);
  a_r8_none_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_type == 3'd0) |-> det_offset == '0);
  a_r6_offset_after_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_type != 3'd0) |-> det_offset >= skp);
  a_r9_sync_dmo_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_type == 3'd5) |-> pre == PRE_SY);
endmodule

// File: tb/burst_seq_finder_bench.sv
module burst_seq_finder_bench;
  localparam int W = 16;
  localparam logic [37:0] SY = 38'b11000001100111001110100111000001100111;
  localparam logic [21:0] N1 = 22'b1101000011101001110100;
  localparam logic [21:0] N2 = 22'b0111101001000011011110;
  localparam logic [11:0] P1 = 12'b001100100011;
  localparam logic [11:0] P2 = 12'b100110101001;
  localparam logic [11:0] P3 = 12'b000101000111;

  logic clk = 0, rst_n = 0, start = 0, bit_valid = 0, bit_in = 0, bit_last = 0;
  logic [2:0] mask = 0;
  logic [W-1:0] skip = 0;
  logic det_valid;
  logic [2:0] det_type;
  logic [W-1:0] det_offset;

  burst_seq_finder #(.W(W)) u_burst_seq_finder (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ncmp = 0, nbad = 0;
  logic st [256];
  int acc [256];
  int n;
  logic done_flag = 0;

  task automatic chk(string r, int got, int exp);
    ncmp++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s got %0d expected %0d", r, got, exp);
    end
  endtask

  function automatic logic patbit(int kind, int j);
    case (kind)
      0: return SY[37-j];
      1: return N1[21-j];
      2: return N2[21-j];
      3: return P1[11-j];
      4: return P2[11-j];
      default: return P3[11-j];
    endcase
  endfunction

  function automatic int patlen(int kind);
    return kind == 0 ? 38 : kind < 3 ? 22 : 12;
  endfunction

  task automatic put(int kind, int p);
    for (int j = 0; j < patlen(kind); j++) st[p+j] = patbit(kind, j);
  endtask

  task automatic noise(int len);
    n = len;
    for (int i = 0; i < 256; i++) st[i] = 1'($urandom);
  endtask

  function automatic bit at(int kind, int p);
    if (p + patlen(kind) > n) return 0;
    for (int j = 0; j < patlen(kind); j++) if (st[p+j] != patbit(kind, j)) return 0;
    return 1;
  endfunction

  task automatic ref_model(input logic [2:0] m, input int sk, output int t, output int o);
    t = 0; o = 0;
    for (int p = sk; p < n; p++) begin
      if (m[0] && at(0, p)) t = 1;
      else if (m[1] && at(1, p)) t = 2;
      else if (m[2] && at(2, p)) t = 3;
      if (t != 0) begin
        o = p;
        if (n >= 12 && at(t == 1 ? 5 : t == 2 ? 3 : 4, 0)) t = t + 4;
        break;
      end
    end
  endtask

  task automatic run(string rt, logic [2:0] m, int sk);
    int et, eo, seen, elat, after;
    bit got;
    ref_model(m, sk, et, eo);
    @(negedge clk);
    start = 1; mask = m; skip = W'(sk);
    @(negedge clk);
    start = 0;
    got = 0; seen = 0; after = 1;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          while ($urandom % 4 == 0) begin
            bit_valid = 0;
            @(negedge clk);
          end
          bit_valid = 1; bit_in = st[i]; bit_last = (i == n - 1);
          @(posedge clk);
          #1 acc[i] = cyc;
          @(negedge clk);
          bit_valid = 0; bit_last = 0;
        end
      end
      begin
        for (int k = 0; k < 3 * n + 80 && !got; k++) begin
          @(negedge clk);
          if (det_valid) begin
            got = 1; seen = cyc;
            chk(rt, int'(det_type), et);
            chk(rt, int'(det_offset), eo);
            @(negedge clk);
            after = det_valid;
          end
        end
      end
    join
    if (!got) begin
      chk("R11 strobe missing", 0, 1);
    end else begin
      if (et == 0) elat = acc[n-1] + 17;
      else if (eo + 38 <= n) elat = acc[eo+37] + 1;
      else elat = acc[n-1] + (eo + 38 - n) + 1;
      chk("R11", seen, elat);
      chk("R10", after, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", int'(det_valid), 0);
    chk("R1", int'(det_type), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1", int'(det_valid), 0);

    for (int i = 0; i < 256; i++) st[i] = 0;
    n = 80; put(0, 10); run("R2 sync", 3'b111, 0);
    n = 60; put(1, 5); run("R3 normal-1", 3'b111, 0);
    noise(70); put(2, 7); run("R3 normal-2", 3'b111, 0);
    noise(100); put(0, 10); put(1, 60); run("R4 mask", 3'b110, 0);
    noise(90); put(1, 0); put(0, 30); run("R5 earliest", 3'b111, 0);
    noise(90); put(2, 0); put(1, 40); run("R5 order", 3'b111, 0);
    noise(100); put(1, 5); put(0, 40); run("R6 skip past", 3'b111, 6);
    noise(100); put(1, 5); put(0, 40); run("R6 skip equal", 3'b111, 5);
    for (int i = 0; i < 256; i++) st[i] = 0;
    n = 60; put(0, 23); run("R7 truncated", 3'b001, 0);
    n = 60; put(0, 22); run("R7 exact sync", 3'b001, 0);
    n = 60; put(1, 38); run("R7 tail normal", 3'b010, 0);
    noise(50); run("R8 none", 3'b000, 0);
    noise(80); put(5, 0); put(0, 20); run("R9 sync dmo", 3'b111, 0);
    noise(80); put(3, 0); put(1, 20); run("R9 normal-1 dmo", 3'b111, 0);
    noise(80); put(4, 0); put(2, 20); run("R9 normal-2 dmo", 3'b111, 0);
    noise(80); put(3, 0); put(0, 20); run("R9 wrong preamble", 3'b111, 0);

    for (int t = 0; t < 60; t++) begin
      int len = 40 + int'($urandom % 160);
      noise(len);
      if ($urandom % 2 == 0) put(3 + int'($urandom % 3), 0);
      for (int h = 0; h < 2; h++) begin
        int kind = int'($urandom % 3);
        int room = n - patlen(kind) - 12;
        if (room > 0) put(kind, 12 + int'($urandom % room));
      end
      run("R5 random", 3'($urandom), int'($urandom % 40));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule